// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Unit

This block computes integer products of two 32-bit operands over several clock cycles. It covers four operation families. The short form returns the low word of the product. The short accumulate form adds a 32-bit addend to that low word. The long form returns the full 64-bit product. The long accumulate form adds a 64-bit addend to that product. The long forms can treat their operands as signed or unsigned. A controller asserts `start_i` for one cycle with operands and mode bits present. The unit raises `busy_o` until the job retires. It then presents the result with a one-cycle `done_o` pulse, and keeps the result on `result_o` until the next accepted start.

The multiplier operand is consumed eight bits per iteration. Each iteration adds one partial product, formed from the current multiplicand and the low eight bits of the multiplier. The multiplicand then moves up one digit and the multiplier moves down one digit. Iteration stops as soon as the remaining multiplier value can add nothing further. For unsigned work that means a value of zero. For signed long work it means zero or all ones, and an all-ones tail is settled by one final subtraction of the shifted multiplicand. Because of this, small multipliers finish in fewer cycles.

The controller has three states:
- IDLE waits for a start.
- CALC steps through digits.
- DONE presents the result for one cycle.

Its transitions are:
- IDLE→CALC on start (load).
- CALC→CALC while multiplier digits remain (step).
- CALC→DONE when the tail is exhausted (finish).
- DONE→IDLE unconditionally.

Top module: `mac_iter_unit`

## Requirements
- R1: With `long_i`=0 and `acc_en_i`=0, `result_o[31:0]` equals the low 32 bits of `op_m_i`×`op_s_i`, and `result_o[63:32]` is zero. In short forms the value of `signed_i` does not change the result.
- R2: With `long_i`=0 and `acc_en_i`=1, `result_o[31:0]` equals (`op_m_i`×`op_s_i` + `acc_lo_i`) modulo 2^32, and `result_o[63:32]` is zero.
- R3: With `long_i`=1, `signed_i`=0 and `acc_en_i`=0, `result_o` equals the unsigned 64-bit product of `op_m_i` and `op_s_i`.
- R4: With `long_i`=1, `signed_i`=1 and `acc_en_i`=0, `result_o` equals the two's complement 64-bit product of `op_m_i` and `op_s_i`.
- R5: With `long_i`=1 and `acc_en_i`=1, `result_o` equals (product per R3 or R4 + {`acc_hi_i`,`acc_lo_i`}) modulo 2^64.
- R6: Latency depends on the multiplier value.
  - Let k be the smallest value in 0..4 for which `op_s_i` shifted right by 8k bits is zero. The shift is logical, except for signed long work, where it is arithmetic and an all-ones value also ends the count.
  - `done_o` is high in the cycle that follows the (k+1)-th rising edge after the edge that samples `start_i`.
- R7: `done_o` is high for exactly one cycle per job. `result_o` keeps its value from `done_o` until the next accepted start.
- R8: `start_i` is ignored while `busy_o` is high. It changes neither the result nor the latency of the running job.
- R9: Flag output follows the `set_flags_i` bit of the job.
  - If that bit was 1, `flag_we_o` is high together with `done_o`. `flag_n_o` then equals result bit 31 for short forms or bit 63 for long forms, and `flag_z_o` is 1 exactly when the result is zero.
  - If that bit was 0, `flag_we_o` stays low.
- R10: After reset, `busy_o`, `done_o` and `flag_we_o` are 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a job; sampled only when idle |
| long_i | input | 1 | 1 = 64-bit result, 0 = 32-bit result |
| acc_en_i | input | 1 | 1 = add the accumulator input |
| signed_i | input | 1 | 1 = signed long multiply (long forms only) |
| set_flags_i | input | 1 | 1 = produce a flag write with the result |
| op_m_i | input | 32 | Multiplicand |
| op_s_i | input | 32 | Multiplier (scanned eight bits per cycle) |
| acc_hi_i | input | 32 | Upper addend word (long accumulate) |
| acc_lo_i | input | 32 | Lower addend word (both accumulate forms) |
| busy_o | output | 1 | Job in progress (CALC or DONE) |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | 64 | Product or accumulated product |
| flag_n_o | output | 1 | Negative flag of the result |
| flag_z_o | output | 1 | Zero flag of the result |
| flag_we_o | output | 1 | Flag write strobe |

## Verification
The assertions check the following on every cycle:
- the single-cycle shape of `done_o`;
- that the latched mode bits stay frozen while digits are being stepped;
- the bound on the iteration count;
- the zero upper word of short results;
- that the result stays stable while idle;
- that a flag write occurs only at the end of a job.

The arithmetic of each form only shows up in the bench's scenarios. This covers the signed fix-up of an all-ones tail, the wrap-around of both accumulate widths, and the exact data-dependent latency. The bench sweeps every mode combination across a grid of multiplicand and multiplier corner values, with start pulses injected during busy jobs.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_DONE = 2'd2
    } mac_state_t;
endpackage

// File: rtl/mac_digit_pp.sv
// Partial product of a wide multiplicand by one narrow multiplier digit,
// built as a chain of conditionally added shifted copies.
module mac_digit_pp #(
    parameter int PROD_W  = 64,
    parameter int DIGIT_W = 8
) (
    input  logic [PROD_W-1:0]  mcand_i,
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [PROD_W-1:0]  pp_o
);
    logic [PROD_W-1:0] chain [0:DIGIT_W];

    assign chain[0] = '0;

    for (genvar j = 0; j < DIGIT_W; j++) begin : g_row
        logic [PROD_W-1:0] row;
        assign row          = digit_i[j] ? (mcand_i << j) : '0;
        assign chain[j + 1] = chain[j] + row;
    end

    assign pp_o = chain[DIGIT_W];
endmodule

// File: rtl/mac_fsm.sv
module mac_fsm
    import mac_pkg::*;
#(
    parameter int MAX_ITER = 4,
    parameter int CNT_W    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tail_done_i,
    output logic load_o,
    output logic step_o,
    output logic finish_o,
    output logic busy_o,
    output logic done_o
);
    mac_state_t state_q, state_d;
    logic [CNT_W-1:0] iter_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_CALC;
            ST_CALC: if (tail_done_i) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o   = 1'b0;
        step_o   = 1'b0;
        finish_o = 1'b0;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_CALC: begin
                busy_o   = 1'b1;
                step_o   = !tail_done_i;
                finish_o = tail_done_i;
            end
            ST_DONE: begin
                busy_o = 1'b1;
                done_o = 1'b1;
            end
            default: ;
        endcase
    end

    // digit counter, kept to bound the iteration loop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_q <= '0;
        end else if (load_o) begin
            iter_q <= '0;
        end else if (step_o) begin
            iter_q <= iter_q + 1'b1;
        end
    end

    AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        iter_q <= CNT_W'(MAX_ITER)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !done_o)); // R8
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
    parameter int DATA_W  = 32,
    parameter int DIGIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              finish_i,
    input  logic              long_i,
    input  logic              acc_en_i,
    input  logic              signed_i,
    input  logic              set_flags_i,
    input  logic [DATA_W-1:0] op_m_i,
    input  logic [DATA_W-1:0] op_s_i,
    input  logic [DATA_W-1:0] acc_hi_i,
    input  logic [DATA_W-1:0] acc_lo_i,
    output logic              tail_done_o,
    output logic              long_o,
    output logic              set_flags_o,
    output logic [2*DATA_W-1:0] acc_o
);
    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] mcand_q;
    logic [DATA_W-1:0] mplier_q;
    logic [PROD_W-1:0] acc_q;
    logic              long_q, sgn_q, sf_q;

    logic              sgn_eff;
    logic [PROD_W-1:0] mcand_init, acc_init, pp, fin_val;
    logic              tail_zero, tail_ones;

    assign sgn_eff    = signed_i & long_i;
    assign mcand_init = {{DATA_W{sgn_eff & op_m_i[DATA_W-1]}}, op_m_i};
    assign acc_init   = !acc_en_i ? '0 :
                        (long_i ? {acc_hi_i, acc_lo_i} : {{DATA_W{1'b0}}, acc_lo_i});

    assign tail_zero   = (mplier_q == '0);
    assign tail_ones   = sgn_q & (&mplier_q);
    assign tail_done_o = tail_zero | tail_ones;

    mac_digit_pp #(
        .PROD_W (PROD_W),
        .DIGIT_W(DIGIT_W)
    ) u_pp (
        .mcand_i(mcand_q),
        .digit_i(mplier_q[DIGIT_W-1:0]),
        .pp_o   (pp)
    );

    // an all-ones signed tail is worth -1 times the shifted multiplicand
    assign fin_val = acc_q - (tail_ones ? mcand_q : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            long_q   <= 1'b0;
            sgn_q    <= 1'b0;
            sf_q     <= 1'b0;
        end else if (load_i) begin
            mcand_q  <= mcand_init;
            mplier_q <= op_s_i;
            acc_q    <= acc_init;
            long_q   <= long_i;
            sgn_q    <= sgn_eff;
            sf_q     <= set_flags_i;
        end else if (step_i) begin
            acc_q    <= acc_q + pp;
            mcand_q  <= mcand_q << DIGIT_W;
            mplier_q <= sgn_q ? DATA_W'($signed(mplier_q) >>> DIGIT_W)
                              : (mplier_q >> DIGIT_W);
        end else if (finish_i) begin
            acc_q <= long_q ? fin_val : {{DATA_W{1'b0}}, fin_val[DATA_W-1:0]};
        end
    end

    assign acc_o       = acc_q;
    assign long_o      = long_q;
    assign set_flags_o = sf_q;

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> ($stable(long_q) && $stable(sgn_q) && $stable(sf_q))); // R8
    AST_STEP_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> ($past(mplier_q) != mplier_q)); // R6
endmodule

// File: rtl/mac_iter_unit.sv
module mac_iter_unit #(
    parameter int DATA_W  = 32,
    parameter int DIGIT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                long_i,
    input  logic                acc_en_i,
    input  logic                signed_i,
    input  logic                set_flags_i,
    input  logic [DATA_W-1:0]   op_m_i,
    input  logic [DATA_W-1:0]   op_s_i,
    input  logic [DATA_W-1:0]   acc_hi_i,
    input  logic [DATA_W-1:0]   acc_lo_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [2*DATA_W-1:0] result_o,
    output logic                flag_n_o,
    output logic                flag_z_o,
    output logic                flag_we_o
);
    localparam int PROD_W   = 2 * DATA_W;
    localparam int MAX_ITER = DATA_W / DIGIT_W;
    localparam int CNT_W    = $clog2(MAX_ITER + 1) + 1;

    logic load, step, finish, tail_done;
    logic long_q, sf_q;

    mac_fsm #(
        .MAX_ITER(MAX_ITER),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .tail_done_i(tail_done),
        .load_o     (load),
        .step_o     (step),
        .finish_o   (finish),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    mac_datapath #(
        .DATA_W (DATA_W),
        .DIGIT_W(DIGIT_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .step_i     (step),
        .finish_i   (finish),
        .long_i     (long_i),
        .acc_en_i   (acc_en_i),
        .signed_i   (signed_i),
        .set_flags_i(set_flags_i),
        .op_m_i     (op_m_i),
        .op_s_i     (op_s_i),
        .acc_hi_i   (acc_hi_i),
        .acc_lo_i   (acc_lo_i),
        .tail_done_o(tail_done),
        .long_o     (long_q),
        .set_flags_o(sf_q),
        .acc_o      (result_o)
    );

    assign flag_n_o  = long_q ? result_o[PROD_W-1] : result_o[DATA_W-1];
    assign flag_z_o  = (result_o == '0);
    assign flag_we_o = done_o & sf_q;

    AST_SHORT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !long_q) |-> (result_o[PROD_W-1:DATA_W] == '0)); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(result_o)); // R7
    AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> $past(busy_o)); // R9
endmodule

// File: tb/mac_iter_unit_bench.sv
module mac_iter_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        long_i = 1'b0, acc_en_i = 1'b0, signed_i = 1'b0, set_flags_i = 1'b0;
    logic [31:0] op_m_i = '0, op_s_i = '0, acc_hi_i = '0, acc_lo_i = '0;
    logic        busy_o, done_o, flag_n_o, flag_z_o, flag_we_o;
    logic [63:0] result_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac_iter_unit u_mac_iter_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_i(long_i),
        .acc_en_i(acc_en_i), .signed_i(signed_i), .set_flags_i(set_flags_i),
        .op_m_i(op_m_i), .op_s_i(op_s_i), .acc_hi_i(acc_hi_i), .acc_lo_i(acc_lo_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_we_o(flag_we_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_iters(logic [31:0] s, bit sg);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] v;
            v = sg ? 32'($signed(s) >>> (8 * k)) : (s >> (8 * k));
            if (v == 32'd0 || (sg && v == 32'hFFFF_FFFF)) return k;
        end
        return 4;
    endfunction

    function automatic logic [63:0] exp_result(logic [31:0] m, logic [31:0] s,
            logic [31:0] hi, logic [31:0] lo, bit lg, bit ac, bit sg);
        logic [63:0] a, b, p;
        if (lg && sg) begin
            a = {{32{m[31]}}, m};
            b = {{32{s[31]}}, s};
        end else begin
            a = {32'd0, m};
            b = {32'd0, s};
        end
        p = a * b;
        if (lg) begin
            if (ac) p = p + {hi, lo};
        end else begin
            p = {32'd0, p[31:0] + (ac ? lo : 32'd0)};
        end
        return p;
    endfunction

    task automatic run_op(input logic [31:0] m, input logic [31:0] s,
                          input logic [31:0] hi, input logic [31:0] lo,
                          input bit lg, input bit ac, input bit sg, input bit sf,
                          input bit disturb);
        logic [63:0] exp;
        logic [63:0] held;
        int n;
        int k;
        bit seen;
        exp = exp_result(m, s, hi, lo, lg, ac, sg);
        k   = exp_iters(s, lg && sg);
        @(negedge clk);
        op_m_i = m; op_s_i = s; acc_hi_i = hi; acc_lo_i = lo;
        long_i = lg; acc_en_i = ac; signed_i = sg; set_flags_i = sf;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (disturb) begin
            // R8: new operands and mode with start held high while busy
            op_m_i = ~m; op_s_i = s ^ 32'h5A5A_0F0F; acc_hi_i = ~hi; acc_lo_i = ~lo;
            long_i = ~lg; acc_en_i = ~ac; signed_i = ~sg; set_flags_i = ~sf;
        end else begin
            start_i = 1'b0;
        end
        n = 0;
        seen = 1'b0;
        while (!seen && n < 12) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (done_o) seen = 1'b1;
        end
        start_i = 1'b0;
        if (!lg) check(exp[63:32] == 32'd0, "R1", result_o, exp);
        if (!lg && !ac) check(result_o == exp, "R1", result_o, exp);
        if (!lg && ac)  check(result_o == exp, "R2", result_o, exp);
        if (lg && !sg && !ac) check(result_o == exp, "R3", result_o, exp);
        if (lg && sg && !ac)  check(result_o == exp, "R4", result_o, exp);
        if (lg && ac)   check(result_o == exp, "R5", result_o, exp);
        if (disturb) check(result_o == exp, "R8", result_o, exp);
        check(seen && n == k + 1, "R6", 64'(n), 64'(k + 1));
        check(flag_we_o == sf, "R9", 64'(flag_we_o), 64'(sf));
        if (sf) begin
            check(flag_n_o == (lg ? exp[63] : exp[31]), "R9", 64'(flag_n_o),
                  64'(lg ? exp[63] : exp[31]));
            check(flag_z_o == (exp == 64'd0), "R9", 64'(flag_z_o), 64'(exp == 64'd0));
        end
        held = result_o;
        @(posedge clk);
        @(negedge clk);
        check(!done_o && !busy_o, "R7", {62'd0, done_o, busy_o}, 64'd0);
        @(posedge clk);
        @(negedge clk);
        check(result_o == held, "R7", result_o, held);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] vals [13];
        vals = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0002, 32'h0000_00FF,
                 32'h0000_0100, 32'h0000_FFFF, 32'h1234_5678, 32'h7FFF_FFFF,
                 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FF80, 32'hDEAD_BEEF,
                 32'h00FF_0000};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check(!busy_o && !done_o && !flag_we_o, "R10",
              {61'd0, busy_o, done_o, flag_we_o}, 64'd0);
        check(result_o == 64'd0, "R10", result_o, 64'd0);
        rst_n = 1'b1;
        for (int mode = 0; mode < 8; mode++) begin
            for (int i = 0; i < 13; i++) begin
                for (int j = 0; j < 13; j++) begin
                    logic [31:0] hi, lo;
                    hi = vals[(i + j) % 13] ^ 32'hA5A5_A5A5;
                    lo = vals[(i * 3 + j) % 13] + 32'h0101_0101;
                    run_op(vals[i], vals[j], hi, lo, mode[2], mode[1], mode[0],
                           ((i + j) % 2) == 0, ((i * 13 + j) % 3) == 0);
                end
            end
        end
        // R2 / R5: wrap of the accumulate sums, and a zero result with flags
        run_op(32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        run_op(32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001,
               1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        // R1: signed bit has no effect in a short form
        run_op(32'h8000_0001, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule